// File: doc/BRIEF.md
# Dual-Processor Interrupt Mailbox Controller

This block sits between a host processor and a coprocessor and lets each side interrupt the other and leave a 4-bit message for it. Both processors reach it through one byte-wide write port that selects one of eight registers by a 4-bit index. A separate byte-wide read port returns one of two flag bytes, picked by `rd_sel`. Three event inputs stand in for the sources outside this block: the coprocessor timer, the coprocessor DMA-done event and the host DMA-done event. Each is a one-cycle pulse.

Every interrupt source has a pending flag. A request sets its flag whatever the enable says. The interrupt line is driven only through the enable, and it is also driven when the enable is switched on while the flag is already pending. The coprocessor side has four sources: a processor IRQ, a timer, a DMA event and an NMI. Each has its own line latch. The first three are ORed into `cop_irq`, and the NMI drives `cop_nmi` alone. The host side has two sources: a processor IRQ and a DMA event. They share one line, which is held by a two-state machine. That line is released only once both host flags read clear.

A second two-state machine follows the coprocessor reset-hold bit. When the bit is released it emits a one-cycle reset pulse, and with it presents a 16-bit start vector loaded by two byte writes.

The two machines work as follows.
- Boot sequencer, states BOOT_RUN and BOOT_HOLD:
  - RUN→HOLD on a control write with the hold bit at 1.
  - HOLD→RUN on a control write with the hold bit at 0. This transition produces the pulse.
- Host line, states HL_IDLE and HL_ASSERT:
  - IDLE→ASSERT when a host source fires.
  - ASSERT→IDLE when both registered host flags are 0 and nothing fires.

Top module: `mbx_ctrl`

Register indices on `wr_addr`:

| Index | Register | Bits |
|---|---|---|
| 0 | host-to-coprocessor control | 7 IRQ request, 6 ready/wait, 5 reset hold, 4 NMI request, 3:0 message to coprocessor |
| 1 | coprocessor-to-host control | 7 host IRQ request, 6 IRQ vector select, 4 NMI vector select, 3:0 message to host |
| 2 | host enable | 7 processor IRQ, 5 DMA-done |
| 3 | host clear | 7 processor IRQ, 5 DMA-done |
| 4 | coprocessor enable | 7 IRQ, 6 timer, 5 DMA, 4 NMI |
| 5 | coprocessor clear | 7 IRQ, 6 timer, 5 DMA, 4 NMI |
| 6 | start vector low byte | |
| 7 | start vector high byte | |

Indices 8 to 15 are unmapped.

## Requirements
- R1: After synchronous reset every flag, enable, line, message, select bit and vector is 0. Both read bytes are 0x00, and `host_irq`, `cop_irq`, `cop_nmi`, `cop_hold`, `cop_wait` and `cop_rst_pulse` are low.
- R2: These requests set their coprocessor flag on the next edge whatever the enable says: control bit 7 (IRQ), control bit 4 (NMI), `timer_evt` and `cop_dma_evt`. A line latch is set only if its enable bit (register 4, bits 7..4) is 1. The enable value written in the same cycle counts.
- R3: Writing an enable bit from 0 to 1 while its flag is pending sets that line on the same edge. Writing 0 to an enable does not drop a line that is already set.
- R4: Writing 1 to a bit of a clear register clears that flag, and on the coprocessor side that line as well, on the next edge. Clear bits written as 0 have no effect.
- R5: When a set event and a clear of the same flag fall in one cycle, the flag ends set.
- R6: `host_irq` rises on the edge where a host source fires. A source fires on a request with its enable set, or when its enable is switched on while its flag is pending. `host_irq` falls on the edge after the one at which both host flags are 0. Disabling an enable does not drop it.
- R7: With `rd_sel`=0, `rd_data` is {host processor-IRQ flag, IRQ vector select, host DMA flag, NMI vector select, message to host[3:0]}, MSB first.
- R8: With `rd_sel`=1, `rd_data` is {IRQ flag, timer flag, DMA flag, NMI flag, message to coprocessor[3:0]}, MSB first.
- R9: `cop_hold` follows control bit 5. A control write that takes the hold from 1 to 0 gives `cop_rst_pulse` high for exactly one cycle, and only then. `cop_rst_vec` = {register 7, register 6}.
- R10: `cop_nmi` follows the NMI line only, and `cop_irq` follows the IRQ, timer and DMA lines only. `cop_wait` follows control bit 6.
- R11: A write to an index from 8 to 15 changes no output and no read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | 0 selects the host flag byte, 1 the coprocessor flag byte |
| rd_data | output | 8 | Selected flag byte |
| timer_evt | input | 1 | Coprocessor timer event pulse |
| cop_dma_evt | input | 1 | Coprocessor DMA-done pulse |
| host_dma_evt | input | 1 | Host DMA-done pulse |
| host_irq | output | 1 | Interrupt line to the host |
| cop_irq | output | 1 | IRQ line to the coprocessor |
| cop_nmi | output | 1 | NMI line to the coprocessor |
| cop_hold | output | 1 | Coprocessor held in reset |
| cop_wait | output | 1 | Ready/wait bit to the coprocessor |
| cop_rst_pulse | output | 1 | One-cycle coprocessor restart pulse |
| cop_rst_vec | output | 16 | Coprocessor start vector |

## Verification
The bench enables a source while its flag is already pending. A design that looked only at new requests would never raise that line. It clears one host flag while the other is still pending, and turns enables off while a line is up. Both must leave `host_irq` high, so a design that drops the line early, or ties it to the enable, shows up at once. It lands a timer event in the same cycle as its clear; a design with clear priority loses the flag. It also writes the reset-hold bit 0 twice in a row and watches for a second pulse, and it writes unmapped indices, which an aliased decoder would turn into writes to a real register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int MSG_W  = 4;
    localparam int VEC_W  = 16;
    localparam int N_COP  = 4;  // 3 irq, 2 timer, 1 dma, 0 nmi
    localparam int N_HOST = 2;  // 1 processor irq, 0 dma
    localparam int N_REGS = 8;

    // register indices on the write port
    typedef enum logic [ADDR_W-1:0] {
        REG_H2C  = 4'd0,
        REG_C2H  = 4'd1,
        REG_HEN  = 4'd2,
        REG_HCLR = 4'd3,
        REG_CEN  = 4'd4,
        REG_CCLR = 4'd5,
        REG_VLO  = 4'd6,
        REG_VHI  = 4'd7
    } reg_id_e;

    // bit positions inside control bytes
    localparam int B_REQ_IRQ = 7;
    localparam int B_READY   = 6;
    localparam int B_HOLD    = 5;
    localparam int B_REQ_NMI = 4;
    localparam int B_IVSEL   = 6;
    localparam int B_NVSEL   = 4;
    localparam int B_COP_LO  = 4;  // coprocessor enable/clear bits 7..4
    localparam int B_H_PROC  = 7;
    localparam int B_H_DMA   = 5;

    typedef enum logic {BOOT_RUN, BOOT_HOLD} boot_st_e;
    typedef enum logic {HL_IDLE, HL_ASSERT} hline_st_e;
endpackage

// File: rtl/mbx_regdec.sv
module mbx_regdec #(
    parameter int ADDR_W = mbx_pkg::ADDR_W,
    parameter int N_REGS = mbx_pkg::N_REGS
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [N_REGS-1:0] stb
);
    for (genvar i = 0; i < N_REGS; i++) begin : g_stb
        assign stb[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    input  logic en_wr_i,
    input  logic en_new_i,
    output logic flag_o,
    output logic fire_o
);
    logic en_eff;
    logic en_rise;

    // enable written this cycle takes effect for a concurrent request
    assign en_eff  = en_wr_i ? en_new_i : en_i;
    assign en_rise = en_wr_i && en_new_i && !en_i;
    assign fire_o  = (set_i && en_eff) || (en_rise && flag_o);

    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/mbx_boot_seq.sv
module mbx_boot_seq (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic hold_new,
    output logic hold_o,
    output logic pulse_o
);
    import mbx_pkg::*;

    boot_st_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= BOOT_RUN;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            BOOT_RUN:  if (ctrl_wr && hold_new)  state_nxt = BOOT_HOLD;
            BOOT_HOLD: if (ctrl_wr && !hold_new) state_nxt = BOOT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= (state == BOOT_HOLD) && (state_nxt == BOOT_RUN);
    end

    assign hold_o = (state == BOOT_HOLD);
endmodule

// File: rtl/mbx_host_line.sv
module mbx_host_line #(
    parameter int N_SRC = mbx_pkg::N_HOST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] fire_i,
    input  logic [N_SRC-1:0] flag_i,
    output logic             irq_o
);
    import mbx_pkg::*;

    hline_st_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= HL_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            HL_IDLE:   if (|fire_i) state_nxt = HL_ASSERT;
            HL_ASSERT: if (flag_i == '0 && !(|fire_i)) state_nxt = HL_IDLE;
        endcase
    end

    always_comb irq_o = (state == HL_ASSERT);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
    parameter int ADDR_W = mbx_pkg::ADDR_W,
    parameter int DATA_W = mbx_pkg::DATA_W,
    parameter int MSG_W  = mbx_pkg::MSG_W,
    parameter int VEC_W  = mbx_pkg::VEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              timer_evt,
    input  logic              cop_dma_evt,
    input  logic              host_dma_evt,
    output logic              host_irq,
    output logic              cop_irq,
    output logic              cop_nmi,
    output logic              cop_hold,
    output logic              cop_wait,
    output logic              cop_rst_pulse,
    output logic [VEC_W-1:0]  cop_rst_vec
);
    import mbx_pkg::*;

    localparam int HALF_V = VEC_W / 2;

    logic [N_REGS-1:0] stb;
    logic              h2c_ready;
    logic [MSG_W-1:0]  h2c_msg;
    logic              c2h_ivsel, c2h_nvsel;
    logic [MSG_W-1:0]  c2h_msg;
    logic [N_HOST-1:0] host_en;
    logic [N_COP-1:0]  cop_en;
    logic [VEC_W-1:0]  vec_q;

    logic [N_COP-1:0]  cop_set, cop_clr, cop_fire, cop_flag, cop_line;
    logic [N_HOST-1:0] host_set, host_clr, host_fire, host_flag, host_en_new;

    mbx_regdec #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .stb(stb)
    );

    // plain registers
    always_ff @(posedge clk) begin
        if (rst) begin
            h2c_ready <= 1'b0;
            h2c_msg   <= '0;
            c2h_ivsel <= 1'b0;
            c2h_nvsel <= 1'b0;
            c2h_msg   <= '0;
            host_en   <= '0;
            cop_en    <= '0;
            vec_q     <= '0;
        end else begin
            if (stb[REG_H2C]) begin
                h2c_ready <= wr_data[B_READY];
                h2c_msg   <= wr_data[MSG_W-1:0];
            end
            if (stb[REG_C2H]) begin
                c2h_ivsel <= wr_data[B_IVSEL];
                c2h_nvsel <= wr_data[B_NVSEL];
                c2h_msg   <= wr_data[MSG_W-1:0];
            end
            if (stb[REG_HEN]) host_en <= host_en_new;
            if (stb[REG_CEN]) cop_en  <= wr_data[B_COP_LO +: N_COP];
            if (stb[REG_VLO]) vec_q[HALF_V-1:0]     <= wr_data[HALF_V-1:0];
            if (stb[REG_VHI]) vec_q[VEC_W-1:HALF_V] <= wr_data[HALF_V-1:0];
        end
    end

    // coprocessor sources: 3 irq, 2 timer, 1 dma, 0 nmi
    assign cop_set = {stb[REG_H2C] && wr_data[B_REQ_IRQ], timer_evt,
                      cop_dma_evt, stb[REG_H2C] && wr_data[B_REQ_NMI]};
    assign cop_clr = stb[REG_CCLR] ? wr_data[B_COP_LO +: N_COP] : '0;

    for (genvar i = 0; i < N_COP; i++) begin : g_cop
        mbx_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .set_i(cop_set[i]), .clr_i(cop_clr[i]),
            .en_i(cop_en[i]), .en_wr_i(stb[REG_CEN]),
            .en_new_i(wr_data[B_COP_LO + i]),
            .flag_o(cop_flag[i]), .fire_o(cop_fire[i])
        );
        always_ff @(posedge clk) begin
            if (rst)              cop_line[i] <= 1'b0;
            else if (cop_fire[i]) cop_line[i] <= 1'b1;
            else if (cop_clr[i])  cop_line[i] <= 1'b0;
        end
    end

    assign cop_irq = |cop_line[N_COP-1:1];
    assign cop_nmi = cop_line[0];

    // host sources: 1 processor irq, 0 dma
    assign host_set    = {stb[REG_C2H] && wr_data[B_REQ_IRQ], host_dma_evt};
    assign host_en_new = {wr_data[B_H_PROC], wr_data[B_H_DMA]};
    assign host_clr    = stb[REG_HCLR] ? {wr_data[B_H_PROC], wr_data[B_H_DMA]} : '0;

    for (genvar j = 0; j < N_HOST; j++) begin : g_host
        mbx_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .set_i(host_set[j]), .clr_i(host_clr[j]),
            .en_i(host_en[j]), .en_wr_i(stb[REG_HEN]),
            .en_new_i(host_en_new[j]),
            .flag_o(host_flag[j]), .fire_o(host_fire[j])
        );
    end

    mbx_host_line #(.N_SRC(N_HOST)) u_hline (
        .clk(clk), .rst(rst), .fire_i(host_fire), .flag_i(host_flag),
        .irq_o(host_irq)
    );

    mbx_boot_seq u_boot (
        .clk(clk), .rst(rst),
        .ctrl_wr(stb[REG_H2C]), .hold_new(wr_data[B_HOLD]),
        .hold_o(cop_hold), .pulse_o(cop_rst_pulse)
    );

    assign cop_wait    = h2c_ready;
    assign cop_rst_vec = vec_q;

    always_comb begin
        if (rd_sel) rd_data = {cop_flag[3], cop_flag[2], cop_flag[1], cop_flag[0], h2c_msg};
        else        rd_data = {host_flag[1], c2h_ivsel, host_flag[0], c2h_nvsel, c2h_msg};
    end
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       timer_evt,
    input logic       host_irq,
    input logic       cop_hold,
    input logic       cop_rst_pulse,
    input logic [1:0] host_flag,
    input logic [3:0] cop_flag,
    input logic [3:0] cop_line
);
    logic cclr_wr;
    assign cclr_wr = wr_en && (wr_addr == 4'd5);

    // R9
    rst_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        cop_rst_pulse |=> !cop_rst_pulse);

    // R9
    rst_pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
        cop_rst_pulse |-> (!cop_hold && $past(cop_hold)));

    // R6
    host_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_irq) |-> ($past(host_flag) == 2'b00));

    // R2
    cop_line_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cop_line & ~cop_flag) == 4'b0000);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_evt && cclr_wr && wr_data[6]) |=> cop_flag[2]);

    // R4
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cclr_wr && wr_data[7]) |=> (!cop_flag[3] && !cop_line[3]));
endmodule

bind mbx_ctrl mbx_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .timer_evt(timer_evt), .host_irq(host_irq), .cop_hold(cop_hold),
    .cop_rst_pulse(cop_rst_pulse), .host_flag(host_flag),
    .cop_flag(cop_flag), .cop_line(cop_line)
);

// File: tb/mbx_ctrl_test.sv
module mbx_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        rd_sel;
    logic [7:0]  rd_data;
    logic        timer_evt, cop_dma_evt, host_dma_evt;
    logic        host_irq, cop_irq, cop_nmi, cop_hold, cop_wait, cop_rst_pulse;
    logic [15:0] cop_rst_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    logic [3:0]  m_cflag, m_cline, m_cen;
    logic [1:0]  m_hflag, m_hen;
    logic        m_hirq, m_hold, m_pulse, m_ready, m_ivsel, m_nvsel;
    logic [3:0]  m_h2c, m_c2h;
    logic [15:0] m_vec;

    always #5 clk = ~clk;

    mbx_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .timer_evt(timer_evt),
        .cop_dma_evt(cop_dma_evt), .host_dma_evt(host_dma_evt),
        .host_irq(host_irq), .cop_irq(cop_irq), .cop_nmi(cop_nmi),
        .cop_hold(cop_hold), .cop_wait(cop_wait), .cop_rst_pulse(cop_rst_pulse),
        .cop_rst_vec(cop_rst_vec)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cflag = '0; m_cline = '0; m_cen = '0; m_hflag = '0; m_hen = '0;
        m_hirq = 0; m_hold = 0; m_pulse = 0; m_ready = 0; m_ivsel = 0; m_nvsel = 0;
        m_h2c = '0; m_c2h = '0; m_vec = '0;
    endtask

    task automatic model_step(input logic we, input logic [3:0] a, input logic [7:0] d,
                              input logic tmr, input logic cdma, input logic hdma);
        logic [3:0] cset, cclr, cfire;
        logic [1:0] hset, hclr, hfire, hnew;
        logic cenwr, henwr;
        cset  = {we && a == 0 && d[7], tmr, cdma, we && a == 0 && d[4]};
        cclr  = (we && a == 5) ? d[7:4] : 4'b0;
        cenwr = we && a == 4;
        for (int i = 0; i < 4; i++) begin
            logic ee;
            ee = cenwr ? d[4+i] : m_cen[i];
            cfire[i] = (cset[i] && ee) || (cenwr && d[4+i] && !m_cen[i] && m_cflag[i]);
        end
        hset  = {we && a == 1 && d[7], hdma};
        hnew  = {d[7], d[5]};
        hclr  = (we && a == 3) ? hnew : 2'b0;
        henwr = we && a == 2;
        for (int j = 0; j < 2; j++) begin
            logic ee;
            ee = henwr ? hnew[j] : m_hen[j];
            hfire[j] = (hset[j] && ee) || (henwr && hnew[j] && !m_hen[j] && m_hflag[j]);
        end
        // host line uses flags from before this edge
        if (!m_hirq) m_hirq = |hfire;
        else if (m_hflag == 2'b00 && !(|hfire)) m_hirq = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (cset[i]) m_cflag[i] = 1'b1; else if (cclr[i]) m_cflag[i] = 1'b0;
            if (cfire[i]) m_cline[i] = 1'b1; else if (cclr[i]) m_cline[i] = 1'b0;
        end
        for (int j = 0; j < 2; j++) begin
            if (hset[j]) m_hflag[j] = 1'b1; else if (hclr[j]) m_hflag[j] = 1'b0;
        end
        if (cenwr) m_cen = d[7:4];
        if (henwr) m_hen = hnew;
        m_pulse = 1'b0;
        if (we && a == 0) begin
            m_pulse = m_hold && !d[5];
            m_hold  = d[5];
            m_ready = d[6];
            m_h2c   = d[3:0];
        end
        if (we && a == 1) begin m_ivsel = d[6]; m_nvsel = d[4]; m_c2h = d[3:0]; end
        if (we && a == 6) m_vec[7:0]  = d;
        if (we && a == 7) m_vec[15:8] = d;
    endtask

    task automatic check_all();
        chk("R6 host_irq", 16'(host_irq), 16'(m_hirq));
        chk("R2,R3,R4 cop_irq", 16'(cop_irq), 16'(|m_cline[3:1]));
        chk("R10 cop_nmi", 16'(cop_nmi), 16'(m_cline[0]));
        chk("R10 cop_wait", 16'(cop_wait), 16'(m_ready));
        chk("R9 cop_hold", 16'(cop_hold), 16'(m_hold));
        chk("R9 cop_rst_pulse", 16'(cop_rst_pulse), 16'(m_pulse));
        chk("R9 cop_rst_vec", cop_rst_vec, m_vec);
        rd_sel = 1'b0; #1;
        chk("R7 host byte", 16'(rd_data), 16'({m_hflag[1], m_ivsel, m_hflag[0], m_nvsel, m_c2h}));
        rd_sel = 1'b1; #1;
        chk("R8 cop byte", 16'(rd_data), 16'({m_cflag, m_h2c}));
    endtask

    // drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic tmr = 0, input logic cdma = 0, input logic hdma = 0);
        wr_en = we; wr_addr = a; wr_data = d;
        timer_evt = tmr; cop_dma_evt = cdma; host_dma_evt = hdma;
        model_step(we, a, d, tmr, cdma, hdma);
        @(negedge clk);
        wr_en = 0; timer_evt = 0; cop_dma_evt = 0; host_dma_evt = 0;
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 4'd0, 8'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_sel = 0;
        timer_evt = 0; cop_dma_evt = 0; host_dma_evt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        // R1 reset state
        check_all();
        chk("R1 host_irq", 16'(host_irq), 16'd0);

        // R2 request without enable: flag only
        step(1, 4'd0, 8'h80);
        chk("R2 flag set", 16'(rd_data[7]), 16'd1);
        chk("R2 no line", 16'(cop_irq), 16'd0);
        // R3 late enable
        step(1, 4'd4, 8'h80);
        chk("R3 late enable", 16'(cop_irq), 16'd1);
        // R3 disabling keeps the line
        step(1, 4'd4, 8'h00);
        chk("R3 disable keeps", 16'(cop_irq), 16'd1);
        // R4 zero clear bits no effect, then clear
        step(1, 4'd5, 8'h40);
        chk("R4 other bit", 16'(cop_irq), 16'd1);
        step(1, 4'd5, 8'h80);
        chk("R4 cleared", 16'(cop_irq), 16'd0);
        // R5 set beats clear
        step(1, 4'd5, 8'h40, 1'b1);
        chk("R5 timer flag", 16'(rd_data[6]), 16'd1);
        // R10 nmi separate
        step(1, 4'd4, 8'h10);
        step(1, 4'd0, 8'h10);
        chk("R10 nmi line", 16'(cop_nmi), 16'd1);
        chk("R10 irq quiet", 16'(cop_irq), 16'd0);
        step(1, 4'd5, 8'hF0);

        // R6 host line
        step(1, 4'd2, 8'hA0);
        step(1, 4'd1, 8'h85);
        chk("R6 raise", 16'(host_irq), 16'd1);
        step(0, 4'd0, 8'd0, 0, 0, 1'b1);
        step(1, 4'd3, 8'h80);
        chk("R6 one flag left", 16'(host_irq), 16'd1);
        step(1, 4'd2, 8'h00);
        chk("R6 disable keeps", 16'(host_irq), 16'd1);
        step(1, 4'd3, 8'h20);
        chk("R6 flags zero, line still up", 16'(host_irq), 16'd1);
        idle();
        chk("R6 dropped", 16'(host_irq), 16'd0);

        // R9 hold release
        step(1, 4'd0, 8'h20);
        step(1, 4'd6, 8'h34);
        step(1, 4'd7, 8'h12);
        step(1, 4'd0, 8'h00);
        chk("R9 pulse", 16'(cop_rst_pulse), 16'd1);
        chk("R9 vector", cop_rst_vec, 16'h1234);
        step(1, 4'd0, 8'h00);
        chk("R9 no second pulse", 16'(cop_rst_pulse), 16'd0);

        // R11 unmapped index
        step(1, 4'd12, 8'hFF);
        chk("R11 cop byte", 16'(rd_data), 16'({m_cflag, m_h2c}));
        step(1, 4'd9, 8'hFF);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a;
            a = 4'($urandom % 10);
            step(($urandom % 4) != 0, a, 8'($urandom),
                 ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule